// File: doc/BRIEF.md
# Dual-Bank Halfword RAM Bus Interface

This block is a bus slave that joins two 16-bit on-chip RAM banks into one 32-bit memory on a pipelined system bus. The high bank stores the upper halfword of every word and the low bank stores the lower halfword. A load reads the same word index from both banks and returns the two halves joined together. A store drives per-byte write enables into whichever bank or banks the access touches.

The RAM takes only one access at a time. A store that arrives while a load is still in flight is written into the array in the cycle it is accepted. Its acknowledge is held back until the load has been acknowledged. A configuration enable gates all bus access. Any request that breaks the access policy gets an error pulse instead of an acknowledge and leaves the array untouched. The policy rejects requests made while the enable is clear, burst requests, misaligned requests and requests with the reserved size code.

Top module: `dbr_ram_slave`

## Requirements
- R1: While `cfg_enable` is 0, an accepted request produces `rsp_err` high in the following cycle, produces no acknowledge and writes nothing.
- R2: The high bank holds data bits 31:16 and the low bank holds bits 15:0 of a word. A load at word index N returns {high bank word N, low bank word N}.
- R3: Store lanes are big-endian, and write data is taken from its own lanes of `req_wdata`. Size code 0 is a byte, code 1 is a halfword and code 2 is a word. Address offset k of a byte selects bits 31-8k down to 24-8k. Halfword offset 0 selects bits 31:16 and offset 2 selects bits 15:0. A word selects all 32 bits. Lanes that are not selected keep their old contents.
- R4: A load of any size returns all 32 bits of the addressed word.
- R5: A load accepted at a clock edge raises `rsp_ack`, with valid `rsp_rdata`, in the second cycle after that edge and not in the first.
- R6: A store accepted while no load is in flight is written at the accepting edge and raises `rsp_ack` in the next cycle.
- R7: A store accepted in the cycle after a load was accepted is written at once. Its `rsp_ack` comes in the cycle after the load's acknowledge, so the two acknowledges are never merged.
- R8: `req_ready` is 0 for a load request while a load is in flight, and 0 for every request while a held-back store acknowledge is still to be issued.
- R9: A burst request is rejected with a one-cycle `rsp_err` pulse in the cycle after the request, gets no acknowledge and writes nothing.
- R10: A halfword at an odd offset, a word at a nonzero offset, or size code 3 is rejected with `rsp_err`, gets no acknowledge and writes nothing.
- R11: A synchronous active-high `rst` clears every pending acknowledge and error but leaves the RAM contents intact.
- R12: At most one acknowledge is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Configuration enable for bus access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_burst | input | 1 | Burst request marker |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data on its natural lanes |
| rsp_ack | output | 1 | Transfer acknowledge |
| rsp_err | output | 1 | Policy violation pulse |
| rsp_rdata | output | 32 | Load data, valid with the load acknowledge |

## Verification
The bench goes after lane steering with stores whose unselected lanes carry junk data. A design with the wrong byte-enable order or the wrong bank split would corrupt neighbouring bytes or swap halfwords. It puts a store directly behind a load and checks that the two acknowledges come in separate consecutive cycles, and that the store's data can be read back afterwards. A design that skipped the deferral would merge or lose an acknowledge. Disabled, burst, misaligned and reserved-size requests are each followed by a readback, so a design that still wrote on an error would be caught. A reset in the middle of a load checks that no stale acknowledge comes out while the array keeps its data.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned BANKS   = DATA_W / HALF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  // Lane i of the mask covers data bits 8i+7:8i; byte offset 0 is lane 3.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [1:0] off);
    logic [LANES-1:0] m;
    m = '0;
    unique case (sz)
      SZ_BYTE: m[3 - off] = 1'b1;
      SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
      SZ_WORD: m = 4'b1111;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_misaligned(input logic [1:0] sz,
                                         input logic [1:0] off);
    logic bad;
    unique case (sz)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = (off != 2'b00);
      default: bad = 1'b1;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             cfg_enable,
  input  logic             req_burst,
  input  logic [1:0]       req_size,
  input  logic [1:0]       addr_off,
  output logic             viol,
  output logic [LANES-1:0] lanes
);

  logic off_bad;

  always_comb begin
    off_bad = is_misaligned(req_size, addr_off);
    viol    = ~cfg_enable | req_burst | off_bad;
    lanes   = viol ? '0 : lane_mask(req_size, addr_off);
  end

  // R9: burst never passes the policy check
  assert_burst_rejected_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_burst) |-> viol);

  // R3: lane count follows the size code
  assert_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !viol) |->
      ($countones(lanes) == ((req_size == SZ_BYTE) ? 1 :
                             (req_size == SZ_HALF) ? 2 : 4)));

  // R10: reserved size never yields lanes
  assert_rsvd_no_lanes_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == SZ_RSVD) |-> (lanes == '0));

endmodule

// File: rtl/dbr_bank.sv
module dbr_bank #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WORDS = 1 << IDX_W,
  localparam int unsigned BYTES = 2
) (
  input  logic             clk,
  input  logic [BYTES-1:0] wr_be,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);

  logic [15:0] mem [WORDS];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic acc_ld,
  input  logic acc_st,
  input  logic acc_bad,
  output logic ready,
  output logic ld_busy,
  output logic ld_ack,
  output logic st_ack,
  output logic err
);

  logic st_defer;

  assign ready = ~st_defer & ~(ld_busy & ~req_write);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_busy  <= 1'b0;
      ld_ack   <= 1'b0;
      st_ack   <= 1'b0;
      st_defer <= 1'b0;
      err      <= 1'b0;
    end else begin
      ld_busy  <= acc_ld;
      ld_ack   <= ld_busy;
      st_ack   <= (acc_st & ~ld_busy) | st_defer;
      st_defer <= acc_st & ld_busy;
      err      <= acc_bad;
    end
  end

  // R12: never two acknowledges together
  assert_single_ack_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_ack, st_ack}));

  // R5: a load is acknowledged two cycles after acceptance
  assert_load_latency_R5: assert property (@(posedge clk) disable iff (rst)
    acc_ld |=> ##1 ld_ack);

  // R7: a deferred store waits while the load acknowledge is out, then follows
  assert_defer_order_R7: assert property (@(posedge clk) disable iff (rst)
    st_defer |-> (ld_ack && !st_ack));
  assert_defer_follow_R7: assert property (@(posedge clk) disable iff (rst)
    st_defer |=> st_ack);

  // R8: no load accepted while one is in flight
  assert_load_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_busy && req_valid && !req_write) |-> !ready);

endmodule

// File: rtl/dbr_ram_slave.sv
module dbr_ram_slave
  import dbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);

  logic             viol;
  logic [LANES-1:0] lanes;
  logic             acc, good_ld, good_st, bad;
  logic [LANES-1:0] wr_lanes;
  logic             ld_busy, ld_ack, st_ack;
  logic [IDX_W-1:0] ld_idx_q;
  logic [IDX_W-1:0] req_idx;

  assign req_idx = req_addr[ADDR_W-1:2];

  dbr_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cfg_enable (cfg_enable),
    .req_burst  (req_burst),
    .req_size   (req_size),
    .addr_off   (req_addr[1:0]),
    .viol       (viol),
    .lanes      (lanes)
  );

  assign acc      = req_valid & req_ready;
  assign good_ld  = acc & ~viol & ~req_write;
  assign good_st  = acc & ~viol & req_write;
  assign bad      = acc & viol;
  assign wr_lanes = good_st ? lanes : '0;

  dbr_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .acc_ld    (good_ld),
    .acc_st    (good_st),
    .acc_bad   (bad),
    .ready     (req_ready),
    .ld_busy   (ld_busy),
    .ld_ack    (ld_ack),
    .st_ack    (st_ack),
    .err       (rsp_err)
  );

  always_ff @(posedge clk) begin
    if (good_ld) ld_idx_q <= req_idx;
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    dbr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .wr_be   (wr_lanes[2*k +: 2]),
      .wr_idx  (req_idx),
      .wr_data (req_wdata[HALF_W*k +: HALF_W]),
      .rd_en   (ld_busy),
      .rd_idx  (ld_idx_q),
      .rd_data (rsp_rdata[HALF_W*k +: HALF_W])
    );
  end

  assign rsp_ack = ld_ack | st_ack;

  // R1: disabled access writes nothing and errors next cycle
  assert_disabled_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> (wr_lanes == '0));
  assert_disabled_err_R1: assert property (@(posedge clk) disable iff (rst)
    (acc && !cfg_enable) |=> rsp_err);

  // R9: burst error pulse follows the request
  assert_burst_err_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && req_burst) |=> (rsp_err && !st_ack));

  // R6: standalone store is acknowledged next cycle
  assert_store_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (good_st && !ld_busy) |=> st_ack);

  // R11: nothing pending right after reset
  assert_reset_clear_R11: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_ack && !rsp_err));

endmodule

// File: tb/sim_dbr_ram_slave.sv
`timescale 1ns/1ps
module sim_dbr_ram_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_ack;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dbr_ram_slave #(.ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, input logic b);
    req_valid = 1'b1; req_write = w; req_size = sz;
    req_addr = a; req_wdata = d; req_burst = b;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
  endtask

  task automatic store(input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input string tag);
    @(negedge clk); drive(1'b1, sz, a, d, 1'b0);
    @(negedge clk); idle();
    check(rsp_ack === 1'b1 && rsp_err === 1'b0, tag, {30'd0, rsp_err, rsp_ack}, 32'd1);
  endtask

  task automatic load(input logic [7:0] a, input logic [1:0] sz,
                      output logic [31:0] q, input string tag);
    @(negedge clk); drive(1'b0, sz, a, 32'd0, 1'b0);
    @(negedge clk); idle();
    check(rsp_ack === 1'b0, {tag, " early ack"}, {31'd0, rsp_ack}, 32'd0);
    @(negedge clk);
    check(rsp_ack === 1'b1, {tag, " ack"}, {31'd0, rsp_ack}, 32'd1);
    q = rsp_rdata;
  endtask

  task automatic rejected(input logic w, input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] d, input logic b, input string tag);
    @(negedge clk); drive(w, sz, a, d, b);
    @(negedge clk); idle();
    check(rsp_err === 1'b1 && rsp_ack === 1'b0, {tag, " err"},
          {30'd0, rsp_err, rsp_ack}, 32'd2);
    @(negedge clk);
    check(rsp_err === 1'b0 && rsp_ack === 1'b0, {tag, " no late ack"},
          {30'd0, rsp_err, rsp_ack}, 32'd0);
  endtask

  task automatic t_reset_state();
    check(rsp_ack === 1'b0 && rsp_err === 1'b0 && req_ready === 1'b1,
          "R11 reset state", {29'd0, req_ready, rsp_err, rsp_ack}, 32'd4);
  endtask

  task automatic t_word();
    logic [31:0] q;
    store(8'h10, 2'd2, 32'h11223344, "R6 word store ack");
    @(negedge clk);
    check(rsp_ack === 1'b0, "R6 single ack", {31'd0, rsp_ack}, 32'd0);
    load(8'h10, 2'd2, q, "R5 word load");
    check(q === 32'h11223344, "R5 word data", q, 32'h11223344);
  endtask

  task automatic t_banks();
    logic [31:0] q;
    store(8'h30, 2'd1, 32'hAAAA1111, "R2 high half store");
    store(8'h32, 2'd1, 32'h22225555, "R2 low half store");
    load(8'h30, 2'd2, q, "R2 joined load");
    check(q === 32'hAAAA5555, "R2 bank split", q, 32'hAAAA5555);
  endtask

  task automatic t_lanes();
    logic [31:0] q;
    store(8'h20, 2'd2, 32'h00000000, "R3 clear");
    store(8'h21, 2'd0, 32'h99EF9999, "R3 byte1");
    store(8'h20, 2'd0, 32'hAB777777, "R3 byte0");
    store(8'h23, 2'd0, 32'h666666CD, "R3 byte3");
    load(8'h20, 2'd2, q, "R3 byte readback");
    check(q === 32'hABEF00CD, "R3 byte lanes", q, 32'hABEF00CD);
    store(8'h24, 2'd2, 32'hFFFFFFFF, "R3 fill");
    store(8'h26, 2'd1, 32'h12345678, "R3 low half");
    load(8'h24, 2'd2, q, "R3 half readback");
    check(q === 32'hFFFF5678, "R3 half lanes", q, 32'hFFFF5678);
  endtask

  task automatic t_full_read();
    logic [31:0] q;
    load(8'h21, 2'd0, q, "R4 byte load");
    check(q === 32'hABEF00CD, "R4 full word on byte load", q, 32'hABEF00CD);
    load(8'h26, 2'd1, q, "R4 half load");
    check(q === 32'hFFFF5678, "R4 full word on half load", q, 32'hFFFF5678);
  endtask

  task automatic t_disabled();
    logic [31:0] q;
    cfg_enable = 1'b0;
    rejected(1'b1, 2'd2, 8'h10, 32'hDEADBEEF, 1'b0, "R1 disabled store");
    rejected(1'b0, 2'd2, 8'h10, 32'h0, 1'b0, "R1 disabled load");
    cfg_enable = 1'b1;
    load(8'h10, 2'd2, q, "R1 readback");
    check(q === 32'h11223344, "R1 no write", q, 32'h11223344);
  endtask

  task automatic t_burst();
    logic [31:0] q;
    rejected(1'b1, 2'd2, 8'h10, 32'hCAFEF00D, 1'b1, "R9 burst store");
    load(8'h10, 2'd2, q, "R9 readback");
    check(q === 32'h11223344, "R9 no write", q, 32'h11223344);
  endtask

  task automatic t_misalign();
    logic [31:0] q;
    rejected(1'b1, 2'd1, 8'h31, 32'h0BAD0BAD, 1'b0, "R10 odd half");
    rejected(1'b1, 2'd2, 8'h32, 32'h0BAD0BAD, 1'b0, "R10 offset word");
    rejected(1'b1, 2'd3, 8'h30, 32'h0BAD0BAD, 1'b0, "R10 reserved size");
    load(8'h30, 2'd2, q, "R10 readback");
    check(q === 32'hAAAA5555, "R10 no write", q, 32'hAAAA5555);
  endtask

  task automatic t_store_behind_load();
    logic [31:0] q;
    @(negedge clk); drive(1'b0, 2'd2, 8'h10, 32'h0, 1'b0);
    @(negedge clk);
    check(rsp_ack === 1'b0, "R5 no ack first cycle", {31'd0, rsp_ack}, 32'd0);
    drive(1'b0, 2'd2, 8'h14, 32'h0, 1'b0);
    #0.5;
    check(req_ready === 1'b0, "R8 second load stalled", {31'd0, req_ready}, 32'd0);
    drive(1'b1, 2'd2, 8'h50, 32'h5A5AA5A5, 1'b0);
    #0.5;
    check(req_ready === 1'b1, "R8 store accepted behind load", {31'd0, req_ready}, 32'd1);
    @(negedge clk); idle();
    check(rsp_ack === 1'b1 && rsp_rdata === 32'h11223344, "R7 load ack first",
          rsp_rdata, 32'h11223344);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h54; req_size = 2'd2;
    #0.5;
    check(req_ready === 1'b0, "R8 held while store ack pending", {31'd0, req_ready}, 32'd0);
    @(negedge clk); idle();
    check(rsp_ack === 1'b1, "R7 deferred store ack", {31'd0, rsp_ack}, 32'd1);
    @(negedge clk);
    check(rsp_ack === 1'b0, "R7 no extra ack", {31'd0, rsp_ack}, 32'd0);
    load(8'h50, 2'd2, q, "R7 readback");
    check(q === 32'h5A5AA5A5, "R7 store written", q, 32'h5A5AA5A5);
  endtask

  task automatic t_mid_reset();
    logic [31:0] q;
    @(negedge clk); drive(1'b0, 2'd2, 8'h30, 32'h0, 1'b0);
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(rsp_ack === 1'b0 && rsp_err === 1'b0, "R11 ack cleared",
          {30'd0, rsp_err, rsp_ack}, 32'd0);
    @(negedge clk);
    check(rsp_ack === 1'b0, "R11 no stale ack", {31'd0, rsp_ack}, 32'd0);
    load(8'h30, 2'd2, q, "R11 readback");
    check(q === 32'hAAAA5555, "R11 contents kept", q, 32'hAAAA5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_word();
    t_banks();
    t_lanes();
    t_full_read();
    t_disabled();
    t_burst();
    t_misalign();
    t_store_behind_load();
    t_mid_reset();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule